// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-driven master for the two-wire serial management bus that configures Ethernet PHYs. Software sees two 32-bit registers. The data register carries the 16-bit value in both directions. The command register packs the PHY address, the register address, a direction flag, a clock-rate select and a self-clearing busy/start bit.

To write a PHY register, software first loads the value into the data register. It then writes the command word with the start bit set. To read, software writes the command with the start bit set and the direction flag clear. In both cases software polls the busy bit until it drops. After a read, the PHY's answer is waiting in the data register.

While a command runs, the block derives the management clock from the system clock. It shifts out a preamble, the start and opcode bits and both addresses. After the turnaround it either drives the data or releases the data line and samples the PHY's reply.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the command and data registers read as zero, the management clock is low and the data line is not driven.
- R2: Command word fields are: bit 0 busy/start, bit 1 direction (1 write, 0 read), bits 8:4 register address, bits 16:12 PHY address, bits 21:20 clock select. The fields read back at those positions. Writing the command with bit 0 clear stores the fields and starts no frame.
- R3: For clock select s, the management clock period is 16·2^s system clocks (16, 32, 64, 128), with equal high and low halves.
- R4: Every frame begins with 32 ones, followed by the start pattern 0 then 1, all driven by the master.
- R5: After the start pattern come the opcode (1,0 for read; 0,1 for write), then the 5-bit PHY address and the 5-bit register address, each most significant bit first.
- R6: In a write frame the master drives the turnaround as 1 then 0, followed by the 16 data-register bits, most significant bit first. The data register reads back the last value written to it in bits 15:0.
- R7: In a read frame the master stops driving the line for both turnaround bits and all 16 data bits. It samples data on rising clock edges, most significant bit first. When the frame ends, the result sits in bits 15:0 of the data register.
- R8: The busy bit reads 1 from the cycle after the start write until the frame ends, and then clears by itself. The management clock stays low and the line stays undriven whenever no frame is running.
- R9: A command write arriving while busy is 1 has no effect: the fields keep their values and no extra frame follows.
- R10: The master changes the value and the enable it drives only when the management clock falls or a frame starts. Both stay constant while the clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 command, 1 data |
| reg_wdata | input | 32 | Register write value |
| reg_rdata | output | 32 | Contents of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven on the management data line |
| mdio_oe | output | 1 | Drive enable for the management data line |
| mdio_i | input | 1 | Sampled management data line |

## Verification
The bench builds the block with its default parameters: a 32-bit preamble and a smallest division of 16. With these values all four clock selects, including the slowest divide-by-128 frame, fit comfortably within the run time. A PHY model in the bench decodes each frame bit by bit, keeps its own register file and answers reads, so write-then-read round trips are checked end to end. The same defaults let the bench hit a command collision in the middle of a frame and watch the line for a spurious follow-on frame.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int PRE_LEN      = 32,
  parameter int DIV_MIN_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN + 1);
  localparam int CNT_W     = DIV_MIN_LOG2 + 3;
  localparam logic [CNT_W-1:0] HALF_BASE = CNT_W'(1) << (DIV_MIN_LOG2 - 1);

  logic             busy_q, wr_q, mdc_q;
  logic [1:0]       sel_q;
  logic [4:0]       phy_q, reg_q;
  logic [15:0]      data_q, rx_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [31:0]      sh_q;

  wire [CNT_W-1:0] half_m1 = (HALF_BASE << sel_q) - CNT_W'(1);
  wire tick     = busy_q && (cnt_q == half_m1);
  wire rise     = tick && !mdc_q;
  wire fall     = tick && mdc_q;
  wire last     = idx_q == IDX_W'(FRAME_LEN - 1);
  wire in_pre   = idx_q < IDX_W'(PRE_LEN);
  wire released = !wr_q && (idx_q >= IDX_W'(PRE_LEN + 14));
  wire in_data  = idx_q >= IDX_W'(PRE_LEN + 16);
  wire cmd_wr   = reg_we && !reg_sel && !busy_q;
  wire unused_wdata = ^{reg_wdata[31:22], reg_wdata[19:17], reg_wdata[11:9], reg_wdata[3:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wr_q   <= 1'b0;
      mdc_q  <= 1'b0;
      sel_q  <= '0;
      phy_q  <= '0;
      reg_q  <= '0;
      data_q <= '0;
      rx_q   <= '0;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
    end else begin
      if (reg_we && reg_sel)
        data_q <= reg_wdata[15:0];
      if (cmd_wr) begin
        busy_q <= reg_wdata[0];
        wr_q   <= reg_wdata[1];
        reg_q  <= reg_wdata[8:4];
        phy_q  <= reg_wdata[16:12];
        sel_q  <= reg_wdata[21:20];
        cnt_q  <= '0;
        idx_q  <= '0;
        mdc_q  <= 1'b0;
        sh_q   <= {2'b01, reg_wdata[1] ? 2'b01 : 2'b10, reg_wdata[16:12],
                   reg_wdata[8:4], 2'b10, data_q};
      end else if (busy_q) begin
        if (tick) begin
          cnt_q <= '0;
          mdc_q <= ~mdc_q;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
        end
        if (rise && !wr_q && in_data)
          rx_q <= {rx_q[14:0], mdio_i};
        if (fall) begin
          if (last) begin
            busy_q <= 1'b0;
            if (!wr_q)
              data_q <= rx_q;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
            if (!in_pre)
              sh_q <= sh_q << 1;
          end
        end
      end
    end
  end

  assign mdc       = mdc_q;
  assign mdio_o    = !busy_q || in_pre || sh_q[31];
  assign mdio_oe   = busy_q && !released;
  assign reg_rdata = reg_sel ? {16'b0, data_q}
                             : {10'b0, sel_q, 3'b0, phy_q, 3'b0, reg_q, 2'b0, wr_q, busy_q};

endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mdc,
  input logic       mdio_o,
  input logic       mdio_oe,
  input logic       reg_we,
  input logic       reg_sel,
  input logic       start_bit,
  input logic [4:0] phy_f,
  input logic       wr_f
);

  assert_mdc_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && !reg_sel && start_bit));

  assert_ignore_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we && !reg_sel |=> $stable(phy_f) && $stable(wr_f));

  assert_line_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mdc && $past(mdc) |-> $stable(mdio_o) && $stable(mdio_oe));

  assert_frame_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> mdio_oe && mdio_o && !mdc);

endmodule

bind mdio_mgmt_master mdio_mgmt_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy_q),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe),
  .reg_we   (reg_we),
  .reg_sel  (reg_sel),
  .start_bit(reg_wdata[0]),
  .phy_f    (phy_q),
  .wr_f     (wr_q)
);

// File: tb/test_mdio_mgmt_master.sv
module test_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic        reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        mdio_i = 1'b1;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_o, mdio_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    logic [31:0] word;
    int          period;
  } exp_t;
  exp_t sb[$];

  logic [15:0] phy_regs [32];
  wire line = mdio_oe ? mdio_o : mdio_i;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // PHY model and monitor
  logic        prev_mdc = 1'b0;
  logic [1:0]  prev_drv = 2'b0;
  logic [1:0]  rise_drv = 2'b0;
  int          k = -1;
  int          since_rise = 0;
  logic [31:0] word = '0;
  bit          frame_rd = 1'b0;
  logic [4:0]  cur_reg = '0;
  int          period_exp = 0;

  always @(negedge clk) begin
    if (mdc && !prev_mdc) begin
      k = k + 1;
      if (k == 0) begin
        frame_rd = 1'b0;
        word = '0;
        if (sb.size() == 0) begin
          check("R9 unexpected frame", 32'd1, 32'd0);
          period_exp = 0;
        end else begin
          period_exp = sb[0].period;
        end
      end else if (period_exp != 0) begin
        check("R3 mdc period", since_rise, period_exp);
      end
      since_rise = 0;
      rise_drv = {mdio_oe, mdio_o};
      if (k < 32) begin
        check("R4 preamble bit", {31'b0, line}, 32'd1);
        check("R4 preamble driven", {31'b0, mdio_oe}, 32'd1);
      end else begin
        word = {word[30:0], line};
      end
      if (k == 35) frame_rd = (word[1:0] == 2'b10);
      if (k == 45) cur_reg = word[4:0];
      if (k >= 46)
        check(frame_rd ? "R7 line released" : "R6 line driven",
              {31'b0, mdio_oe}, frame_rd ? 32'd0 : 32'd1);
      if (k == 63) begin
        if (sb.size() != 0) begin
          check("R5 frame contents", word, sb[0].word);
          void'(sb.pop_front());
        end
        if (word[29:28] == 2'b01) phy_regs[word[22:18]] = word[15:0];
        mdio_i = 1'b1;
        k = -1;
      end
    end
    if (!mdc && prev_mdc) begin
      check("R10 held while mdc high", {30'b0, prev_drv}, {30'b0, rise_drv});
      if (frame_rd && k >= 0) begin
        if (k == 46) mdio_i = 1'b0;
        else if (k >= 47 && k <= 62) mdio_i = phy_regs[cur_reg][62-k];
      end
    end
    since_rise++;
    prev_mdc = mdc;
    prev_drv = {mdio_oe, mdio_o};
  end

  task automatic bus_write(logic sel, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [31:0] cmd_word(bit wr, logic [4:0] phy, logic [4:0] rg,
                                           logic [1:0] sel, bit go);
    return {10'b0, sel, 3'b0, phy, 3'b0, rg, 2'b0, wr, go};
  endfunction

  task automatic push_exp(bit wr, logic [4:0] phy, logic [4:0] rg, logic [1:0] sel,
                          logic [15:0] d);
    exp_t e;
    e.period = 16 << sel;
    e.word = {2'b01, wr ? 2'b01 : 2'b10, phy, rg, 2'b10, d};
    sb.push_back(e);
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    reg_sel = 1'b0;
    @(negedge clk);
    while (reg_rdata[0] && n < 20000) begin
      @(negedge clk);
      n++;
    end
    check(req, {31'b0, reg_rdata[0]}, 32'd0);
  endtask

  task automatic run_cmd(bit wr, logic [4:0] phy, logic [4:0] rg, logic [1:0] sel,
                         logic [15:0] d);
    logic [15:0] exp_d;
    exp_d = wr ? d : phy_regs[rg];
    push_exp(wr, phy, rg, sel, exp_d);
    if (wr) bus_write(1'b1, {16'b0, d});
    bus_write(1'b0, cmd_word(wr, phy, rg, sel, 1'b1));
    reg_sel = 1'b0;
    @(negedge clk);
    check("R8 busy set while running", {31'b0, reg_rdata[0]}, 32'd1);
    wait_idle("R8 busy clears");
    check("R8 idle mdc low, line undriven", {30'b0, mdc, mdio_oe}, 32'd0);
    check("R5 frame observed", sb.size(), 0);
    if (!wr) begin
      reg_sel = 1'b1;
      @(negedge clk);
      check("R7 read result in data register", reg_rdata, {16'b0, exp_d});
      reg_sel = 1'b0;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h5A00 | 16'(i * 7);
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 command after reset", reg_rdata, 32'd0);
    check("R1 mdc/oe after reset", {30'b0, mdc, mdio_oe}, 32'd0);
    reg_sel = 1'b1;
    @(negedge clk);
    check("R1 data after reset", reg_rdata, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: field positions, no start with bit 0 clear
    bus_write(1'b0, cmd_word(1'b1, 5'h15, 5'h0A, 2'd2, 1'b0));
    reg_sel = 1'b0;
    @(negedge clk);
    check("R2 field readback", reg_rdata, 32'h0021_50A2);
    repeat (100) @(negedge clk);
    check("R2 no frame without start", {30'b0, mdc, mdio_oe}, 32'd0);

    // R6: data register readback
    bus_write(1'b1, 32'hFFFF_1234);
    reg_sel = 1'b1;
    @(negedge clk);
    check("R6 data register readback", reg_rdata, 32'h0000_1234);

    // Frames across all clock selects
    run_cmd(1'b1, 5'h05, 5'h03, 2'd0, 16'hBEEF);
    run_cmd(1'b0, 5'h05, 5'h03, 2'd0, 16'h0);
    run_cmd(1'b0, 5'h1F, 5'h1F, 2'd1, 16'h0);
    run_cmd(1'b1, 5'h00, 5'h00, 2'd2, 16'h0001);
    run_cmd(1'b0, 5'h11, 5'h00, 2'd3, 16'h0);
    run_cmd(1'b0, 5'h0A, 5'h15, 2'd0, 16'h0);

    // R9: command during busy is ignored
    push_exp(1'b0, 5'h02, 5'h07, 2'd0, phy_regs[7]);
    bus_write(1'b0, cmd_word(1'b0, 5'h02, 5'h07, 2'd0, 1'b1));
    repeat (50) @(negedge clk);
    bus_write(1'b0, cmd_word(1'b1, 5'h09, 5'h01, 2'd1, 1'b1));
    reg_sel = 1'b0;
    @(negedge clk);
    check("R9 fields kept while busy", reg_rdata, cmd_word(1'b0, 5'h02, 5'h07, 2'd0, 1'b1));
    wait_idle("R9 busy clears");
    check("R9 fields after frame", reg_rdata, cmd_word(1'b0, 5'h02, 5'h07, 2'd0, 1'b0));
    reg_sel = 1'b1;
    @(negedge clk);
    check("R9 read data intact", reg_rdata, {16'b0, phy_regs[7]});
    begin
      int rises = 0;
      logic pm = 1'b0;
      repeat (2000) begin
        @(negedge clk);
        if (mdc && !pm) rises++;
        pm = mdc;
      end
      check("R9 no follow-on frame", rises, 0);
    end
    check("R9 scoreboard drained", sb.size(), 0);

    summary();
    $finish;
  end

endmodule